// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Tags

This block sits between a serial receiver's deserializer and the host. Every character that the receiver finishes is written in together with three error bits (for example parity, framing and break), and the pair is kept together as one tagged entry. The oldest entry is always visible as the holding register on `hold_data` and `hold_err`. The host takes it with a one-cycle `rd_strobe`, and on that same edge the next entry, with its own error bits, appears on the outputs.

The block runs in one of two modes, chosen by `fifo_en`. In buffered mode it holds up to 64 entries, and the receive interrupt fires when the fill level reaches a trigger level that `trig_sel` picks. In single-register mode only one character is held, and the interrupt fires as soon as that character is present. In buffered mode, data that sits below the trigger level for too long raises a character-timeout interrupt. Its length follows the configured word length and is counted in bit times given by `baud_tick`.

Top module: `rx_tagged_fifo`

## Requirements
- R1: In buffered mode the block holds up to 64 entries of 8 data bits plus 3 error bits, and `fill_level` reports the count from 0 to 64.
- R2: A character written into an empty block appears on `hold_data`/`hold_err` on the clock edge that accepts it. A `rd_strobe` while `data_ready` is high removes the head entry on its edge.
- R3: On each read, `hold_err` changes on the same edge to the error bits stored with the new head entry. Entries leave in the order they arrived.
- R4: When `fifo_en` is 0 the block holds exactly one character, and `fill_level` never exceeds 1.
- R5: A write that arrives while the block is full (64 entries, or 1 in single-register mode), with no read in the same cycle, is discarded and sets `overrun`. `fill_level` and the head entry stay unchanged. A read and a write in the same cycle on a full block are both accepted.
- R6: `overrun` stays high until the next `rd_strobe`, and it clears on that strobe's edge.
- R7: The trigger level is selected by `trig_sel`: 0 gives 1 entry, 1 gives 16, 2 gives 32, 3 gives 56. In buffered mode `rx_irq` is high while `fill_level` is at or above the trigger level.
- R8: In single-register mode `rx_irq` is high while the holding register contains a character.
- R9: `rx_int_en` low forces both `rx_irq` and `timeout_irq` low. Raising it shows any pending condition without delay.
- R10: In buffered mode, with the fill level between 1 and the trigger level minus one, `timeout_irq` rises after 4*(word_len+7)+12 `baud_tick` pulses with no accepted write and no read. `word_len` 0..3 means 5..8 data bits, plus one start bit and one stop bit.
- R11: An accepted write or a read clears the timeout and restarts its count. No timeout is raised in single-register mode.
- R12: Any change of `fifo_en` empties the block, clears `overrun` and clears the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = 64-entry buffered mode, 0 = single-register mode |
| trig_sel | input | 2 | Trigger level select (1, 16, 32, 56) |
| word_len | input | 2 | Data bits per character minus 5 |
| rx_int_en | input | 1 | Receive interrupt enable |
| baud_tick | input | 1 | One pulse per serial bit time |
| wr_valid | input | 1 | Receiver delivers a character this cycle |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error bits for the character |
| rd_strobe | input | 1 | Host reads the holding register |
| hold_data | output | 8 | Head entry data |
| hold_err | output | 3 | Head entry error bits |
| data_ready | output | 1 | At least one entry present |
| fill_level | output | 7 | Number of stored entries |
| overrun | output | 1 | A character was lost to a full buffer |
| rx_irq | output | 1 | Receive data interrupt |
| timeout_irq | output | 1 | Character timeout interrupt |

## Verification
The bench fills the buffer to exactly 64 entries, each with a distinct error pattern. It then reads everything back and checks that data and error bits move together. A design that updated the flags one read late, or that lost the tag pairing, shows a mismatch on the first pop. A read and a write in the same cycle on a full buffer must both be accepted, and a write at full with no read must be dropped: a design that wrapped its pointer or counted 65 would corrupt the head or the level. The timeout is measured to the exact tick for the shortest and the longest word length, including a restart caused by a second write, so an off-by-one in the limit or a missing restart gets caught. The bench also checks the four trigger thresholds one entry below and at the level, the single-register overrun, the interrupt gating, and the flush on a mode change.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  // serial bits per character: start + (5 + code) data + stop
  function automatic int char_bits(input logic [1:0] wl_code);
    return int'(wl_code) + 7;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 11,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              single,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_req,
  output logic [WORD_W-1:0] head_word,
  output logic [LVL_W-1:0]  level,
  output logic              accept,
  output logic              rd_fire,
  output logic              ovr_hit
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, rd_next;
  logic              full, empty;

  assign empty   = (level == '0);
  assign full    = single ? !empty : (level == LVL_W'(DEPTH));
  assign rd_fire = rd_req && !empty && !flush;
  assign accept  = wr_valid && (!full || rd_fire) && !flush;
  assign ovr_hit = wr_valid && full && !rd_fire && !flush;
  assign rd_next = rd_fire ? rd_ptr + PTR_W'(1) : rd_ptr;

  // storage array: write-only port, no reset, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wr_word;
  end

  // registered head read with bypass when the next head is being written
  always_ff @(posedge clk) begin
    if (accept && (wr_ptr == rd_next)) head_word <= wr_word;
    else                                head_word <= mem[rd_next];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + PTR_W'(1);
      rd_ptr <= rd_next;
      case ({accept, rd_fire})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxf_char_timer.sv
module rxf_char_timer #(
  parameter int TO_CHARS = 4,
  parameter int TO_EXTRA = 12,
  localparam int TO_MAX  = TO_CHARS * 10 + TO_EXTRA,
  localparam int TO_W    = $clog2(TO_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       armed,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] word_len,
  output logic       expired
);
  import rxf_pkg::*;

  logic [TO_W-1:0] limit;
  logic [TO_W-1:0] cnt;

  always_comb limit = TO_W'(TO_CHARS * char_bits(word_len) + TO_EXTRA);

  always_ff @(posedge clk) begin
    if (rst || restart || !armed) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      if (cnt == limit - TO_W'(1)) expired <= 1'b1;
      else                         cnt     <= cnt + TO_W'(1);
    end
  end
endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo #(
  parameter int DEPTH    = 64,
  parameter int TRIG_L0  = 1,
  parameter int TRIG_L1  = 16,
  parameter int TRIG_L2  = 32,
  parameter int TRIG_L3  = 56,
  parameter int TO_CHARS = 4,
  parameter int TO_EXTRA = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fifo_en,
  input  logic [1:0]                   trig_sel,
  input  logic [1:0]                   word_len,
  input  logic                         rx_int_en,
  input  logic                         baud_tick,
  input  logic                         wr_valid,
  input  logic [7:0]                   wr_data,
  input  logic [2:0]                   wr_err,
  input  logic                         rd_strobe,
  output logic [7:0]                   hold_data,
  output logic [2:0]                   hold_err,
  output logic                         data_ready,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level,
  output logic                         overrun,
  output logic                         rx_irq,
  output logic                         timeout_irq
);
  import rxf_pkg::*;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic            mode_q, flush;
  logic            accept, rd_fire, ovr_hit, expired, armed;
  logic [LVL_W-1:0] level, trig_lvl;
  rx_word_t        in_word, head;

  always_ff @(posedge clk) mode_q <= fifo_en;
  assign flush = !rst && (mode_q != fifo_en);

  assign in_word = '{err: wr_err, data: wr_data};

  rxf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .single(!fifo_en),
    .wr_valid(wr_valid), .wr_word(in_word), .rd_req(rd_strobe),
    .head_word(head), .level(level), .accept(accept),
    .rd_fire(rd_fire), .ovr_hit(ovr_hit)
  );

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = LVL_W'(TRIG_L0);
      2'd1:    trig_lvl = LVL_W'(TRIG_L1);
      2'd2:    trig_lvl = LVL_W'(TRIG_L2);
      default: trig_lvl = LVL_W'(TRIG_L3);
    endcase
  end

  assign armed = fifo_en && (level != '0) && (level < trig_lvl);

  rxf_char_timer #(.TO_CHARS(TO_CHARS), .TO_EXTRA(TO_EXTRA)) u_timer (
    .clk(clk), .rst(rst || flush), .armed(armed),
    .restart(accept || rd_fire), .tick(baud_tick),
    .word_len(word_len), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst || flush)  overrun <= 1'b0;
    else if (ovr_hit)  overrun <= 1'b1;
    else if (rd_strobe) overrun <= 1'b0;
  end

  assign hold_data   = head.data;
  assign hold_err    = head.err;
  assign fill_level  = level;
  assign data_ready  = (level != '0);
  assign rx_irq      = rx_int_en && (fifo_en ? (level >= trig_lvl) : data_ready);
  assign timeout_irq = rx_int_en && expired;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             rx_int_en,
  input logic             wr_valid,
  input logic             rd_strobe,
  input logic [LVL_W-1:0] fill_level,
  input logic             overrun,
  input logic             rx_irq,
  input logic             timeout_irq
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill_level <= LVL_W'(DEPTH));

  p_read_pops_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && fill_level != '0 && !wr_valid && $stable(fifo_en))
      |=> (fill_level == $past(fill_level) - LVL_W'(1)));

  p_single_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && $past(!fifo_en)) |-> (fill_level <= LVL_W'(1)));

  p_drop_full_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !rd_strobe && $stable(fifo_en) &&
     fill_level == (fifo_en ? LVL_W'(DEPTH) : LVL_W'(1)))
      |=> (overrun && fill_level == $past(fill_level)));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_int_en |-> (!rx_irq && !timeout_irq));

  p_timeout_data_r10: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |-> (fill_level != '0 && fifo_en));
endmodule

bind rx_tagged_fifo rxf_checker #(.DEPTH(DEPTH)) u_rxf_checker (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_int_en(rx_int_en),
  .wr_valid(wr_valid), .rd_strobe(rd_strobe), .fill_level(fill_level),
  .overrun(overrun), .rx_irq(rx_irq), .timeout_irq(timeout_irq)
);

// File: tb/test_rx_tagged_fifo.sv
module test_rx_tagged_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic [1:0] word_len = 2'd0;
  logic       rx_int_en = 1'b1;
  logic       baud_tick = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic       rd_strobe = 1'b0;
  logic [7:0] hold_data;
  logic [2:0] hold_err;
  logic       data_ready, overrun, rx_irq, timeout_irq;
  logic [6:0] fill_level;

  int vectors = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_tagged_fifo i_rx_tagged_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .word_len(word_len), .rx_int_en(rx_int_en), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_err(wr_err),
    .rd_strobe(rd_strobe), .hold_data(hold_data), .hold_err(hold_err),
    .data_ready(data_ready), .fill_level(fill_level), .overrun(overrun),
    .rx_irq(rx_irq), .timeout_irq(timeout_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    wr_valid = 1'b1; wr_data = d; wr_err = e;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic pop();
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    fifo_en = mode;
    rst = 1'b1;
    steps(2);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    check("R1 reset level", fill_level, 0);
    check("R2 reset ready", data_ready, 0);
    check("R6 reset overrun", overrun, 0);
    check("R7 reset irq", rx_irq, 0);
    check("R10 reset timeout", timeout_irq, 0);
  endtask

  task automatic t_full_order();
    do_reset(1'b1);
    trig_sel = 2'd3;
    push(8'h00, 3'd0);
    check("R2 head after first write", hold_data, 8'h00);
    for (int i = 1; i < 64; i++) push(8'(i), 3'(i));
    check("R1 level at full", fill_level, 64);
    // read and write together on a full buffer
    wr_valid = 1'b1; wr_data = 8'hC0; wr_err = 3'd5; rd_strobe = 1'b1;
    step();
    wr_valid = 1'b0; rd_strobe = 1'b0;
    check("R5 simultaneous level", fill_level, 64);
    check("R5 simultaneous no overrun", overrun, 0);
    check("R3 head after pop", hold_data, 1);
    check("R3 err after pop", hold_err, 1);
    push(8'hAA, 3'd7);
    check("R5 overrun set", overrun, 1);
    check("R5 level unchanged", fill_level, 64);
    check("R5 head unchanged", hold_data, 1);
    steps(3);
    check("R6 overrun held", overrun, 1);
    for (int i = 1; i < 64; i++) begin
      check("R3 data order", hold_data, i);
      check("R3 err follows head", hold_err, i % 8);
      pop();
      if (i == 1) check("R6 overrun cleared by read", overrun, 0);
    end
    check("R3 last data", hold_data, 8'hC0);
    check("R3 last err", hold_err, 5);
    pop();
    check("R2 empty after drain", data_ready, 0);
  endtask

  task automatic t_single();
    do_reset(1'b0);
    push(8'h11, 3'd3);
    check("R8 irq with char", rx_irq, 1);
    check("R4 level one", fill_level, 1);
    push(8'h22, 3'd4);
    check("R4 level capped", fill_level, 1);
    check("R5 single overrun", overrun, 1);
    check("R5 single head kept", hold_data, 8'h11);
    check("R5 single err kept", hold_err, 3);
    steps(70);
    check("R11 no timeout single mode", timeout_irq, 0);
    pop();
    check("R8 irq after read", rx_irq, 0);
    check("R4 empty", fill_level, 0);
  endtask

  task automatic t_trigger(input logic [1:0] sel, input int lvl);
    do_reset(1'b1);
    trig_sel = sel;
    for (int i = 0; i < lvl - 1; i++) push(8'(i), 3'd0);
    check("R7 below trigger", rx_irq, 0);
    push(8'hFF, 3'd0);
    check("R7 at trigger", rx_irq, 1);
    pop();
    check("R7 after read below", rx_irq, (lvl == 1) ? 0 : 0);
  endtask

  task automatic t_timeout_short();
    do_reset(1'b1);
    trig_sel = 2'd1; word_len = 2'd0;
    push(8'h5A, 3'd2);
    steps(39);
    check("R10 no timeout at 39", timeout_irq, 0);
    step();
    check("R10 timeout at 40", timeout_irq, 1);
    pop();
    check("R11 read clears timeout", timeout_irq, 0);
  endtask

  task automatic t_timeout_long();
    do_reset(1'b1);
    trig_sel = 2'd2; word_len = 2'd3;
    push(8'h01, 3'd0);
    steps(30);
    push(8'h02, 3'd0);
    steps(51);
    check("R11 write restarts count", timeout_irq, 0);
    step();
    check("R10 timeout at 52", timeout_irq, 1);
    push(8'h03, 3'd0);
    check("R11 write clears timeout", timeout_irq, 0);
  endtask

  task automatic t_gating();
    do_reset(1'b1);
    trig_sel = 2'd1; word_len = 2'd0; rx_int_en = 1'b0;
    push(8'h10, 3'd0);
    steps(45);
    check("R9 timeout masked", timeout_irq, 0);
    rx_int_en = 1'b1;
    #1;
    check("R9 pending shown", timeout_irq, 1);
    rx_int_en = 1'b0; trig_sel = 2'd0;
    #1;
    check("R9 rx irq masked", rx_irq, 0);
    rx_int_en = 1'b1;
    #1;
    check("R9 rx irq shown", rx_irq, 1);
  endtask

  task automatic t_flush();
    do_reset(1'b1);
    trig_sel = 2'd3;
    for (int i = 0; i < 3; i++) push(8'(i), 3'd1);
    fifo_en = 1'b0;
    step();
    check("R12 flush on mode change", fill_level, 0);
    check("R12 ready cleared", data_ready, 0);
  endtask

  initial begin
    t_reset_state();
    t_full_order();
    t_single();
    t_trigger(2'd0, 1);
    t_trigger(2'd1, 16);
    t_trigger(2'd2, 32);
    t_trigger(2'd3, 56);
    t_timeout_short();
    t_timeout_long();
    t_gating();
    t_flush();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      vectors++;
      bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule